// File: doc/BRIEF.md
# Oversampling Serial Receiver with Character Queue

This block receives asynchronous serial characters from a raw input line. An external enable tick gives the oversampling rate. Each bit period is 16 ticks, or 8 ticks when the double-speed input is high. The line passes through a two-stage synchronizer. A falling edge seen on a tick while the receiver is waiting marks the first sample of a start bit, and that event sets the bit-timing phase. Every later bit is decided by a majority vote of three samples at the centre of the bit. This filters short noise on the line.

A character is one start bit, eight data bits sent least significant bit first, an optional parity bit (even or odd) and one stop bit. The finished character goes into a two-entry queue together with its own parity-error and framing-error flags. On the host side, a data-available flag and the head entry are visible at all times. A read strobe removes the head entry. Clearing the receive enable abandons any frame in progress at once and empties the queue.

The frame controller has five states. IDLE waits for a low sample. START votes at the start-bit centre: a high vote returns to IDLE as a glitch, and a low vote goes to DATA. DATA shifts in eight voted bits and then goes to PARITY if parity is enabled, otherwise to STOP. PARITY votes the parity bit and goes to STOP. STOP votes the stop bit, writes the character into the queue and returns to IDLE. Whenever the enable is low, every state goes straight to IDLE.

Top module: `osr_uart_rx`

## Requirements
- R1: With `dbl_speed` low, a bit period is 16 ticks. The tick on which a low line is first seen while waiting is sample 1 of the start bit.
- R2: With `dbl_speed` high, a bit period is 8 ticks. The speed mode, parity enable and parity sense are captured when the start is detected.
- R3: Each bit takes the majority value of samples N/2, N/2+1 and N/2+2 of its period, where N is 16 or 8. One wrong centre sample does not change the bit.
- R4: If the start-bit vote is high, the receiver returns to waiting and stores no character.
- R5: The eight data bits arrive least significant bit first and appear on `rd_data`.
- R6: With `par_en` high, a parity bit follows the data. `par_odd`=0 selects even parity and `par_odd`=1 selects odd parity. A mismatch sets `rd_par_err` for that character only. With `par_en` low, the flag is 0.
- R7: A low stop-bit vote sets `rd_frm_err` for that character. The character is stored at the stop-bit vote.
- R8: The queue holds two characters in arrival order. `data_avail` is high while it is not empty. `rd_stb` removes the head, and `rd_stb` on an empty queue has no effect.
- R9: A character that arrives while the queue is full is dropped and sets `overrun`. `overrun` stays set until the next read of a non-empty queue.
- R10: When a character arrives in the same cycle as a read of a full queue, the character is kept and no overrun occurs.
- R11: While `rx_en` is low, the frame in progress is discarded, the queue is emptied and `overrun` is cleared. A frame sent while the enable is low stores nothing.
- R12: After reset the queue is empty and `overrun` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversampling enable, one cycle per sample |
| dbl_speed | input | 1 | 1: 8 samples per bit, 0: 16 samples per bit |
| rx_en | input | 1 | Receive enable; low aborts the frame and empties the queue |
| par_en | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| rxd | input | 1 | Asynchronous serial input line |
| rd_stb | input | 1 | Removes the head character |
| data_avail | output | 1 | Queue not empty |
| rd_data | output | 8 | Head character data |
| rd_par_err | output | 1 | Parity error of the head character |
| rd_frm_err | output | 1 | Framing error of the head character |
| overrun | output | 1 | Sticky character-dropped flag |

## Verification
Two events can fall in the same cycle: the stop-bit vote writing a character into the queue, and a host read. The bench generates every tick itself. It therefore knows which tick carries the stop-bit vote, and it asserts `rd_stb` on exactly that tick while the queue is full. The expected result is that the head leaves, the new character lands behind the older one, and `overrun` stays low. The bench also raises the read strobe on an empty queue, and it drops the enable in the middle of a frame. In both cases it then compares the flags and queue contents with its own model.

// File: rtl/osr_uart_rx_pkg.sv
package osr_uart_rx_pkg;

    localparam int CHAR_W = 8;

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              par_err;
        logic              frm_err;
    } rx_char_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } rx_state_t;

endpackage

// File: rtl/osr_uart_rx_sync.sv
module osr_uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= {pipe_q[STAGES-2:0], din};
    end

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/osr_uart_rx_fsm.sv
module osr_uart_rx_fsm
    import osr_uart_rx_pkg::*;
#(
    parameter int OSR_NORM = 16,
    parameter int OSR_FAST = 8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clr,
    input  logic     tick,
    input  logic     dbl_speed,
    input  logic     par_en,
    input  logic     par_odd,
    input  logic     line,
    output logic     push,
    output rx_char_t push_char,
    output logic     busy
);
    localparam int CW = $clog2(OSR_NORM);
    localparam int BW = $clog2(CHAR_W);

    rx_state_t         state_q, state_d;
    logic [CW-1:0]     cnt_q;
    logic [BW-1:0]     bit_q;
    logic [CHAR_W-1:0] shreg_q;
    logic              s_a_q, s_b_q, pbit_q;
    logic              fast_q, pen_q, podd_q;

    logic [CW-1:0] osr, mid;
    logic          at_a, at_b, at_vote, at_wrap, vote, last_bit;

    always_comb begin
        osr      = fast_q ? CW'(OSR_FAST - 1) : CW'(OSR_NORM - 1);
        mid      = fast_q ? CW'(OSR_FAST / 2) : CW'(OSR_NORM / 2);
        at_a     = (cnt_q == mid - CW'(1));
        at_b     = (cnt_q == mid);
        at_vote  = (cnt_q == mid + CW'(1));
        at_wrap  = (cnt_q == osr);
        vote     = (s_a_q & s_b_q) | (s_a_q & line) | (s_b_q & line);
        last_bit = (bit_q == BW'(CHAR_W - 1));
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (clr) begin
            state_d = ST_IDLE;
        end else if (tick) begin
            unique case (state_q)
                ST_IDLE:   if (!line) state_d = ST_START;
                ST_START:  if (at_vote) state_d = vote ? ST_IDLE : ST_DATA;
                ST_DATA:   if (at_vote && last_bit) state_d = pen_q ? ST_PARITY : ST_STOP;
                ST_PARITY: if (at_vote) state_d = ST_STOP;
                ST_STOP:   if (at_vote) state_d = ST_IDLE;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // datapath and sample timing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            bit_q   <= '0;
            shreg_q <= '0;
            s_a_q   <= 1'b1;
            s_b_q   <= 1'b1;
            pbit_q  <= 1'b0;
            fast_q  <= 1'b0;
            pen_q   <= 1'b0;
            podd_q  <= 1'b0;
        end else if (clr) begin
            cnt_q <= '0;
            bit_q <= '0;
        end else if (tick) begin
            if (state_q == ST_IDLE) begin
                if (!line) begin
                    cnt_q  <= CW'(1);
                    bit_q  <= '0;
                    fast_q <= dbl_speed;
                    pen_q  <= par_en;
                    podd_q <= par_odd;
                end
            end else begin
                cnt_q <= at_wrap ? '0 : cnt_q + CW'(1);
                if (at_a) s_a_q <= line;
                if (at_b) s_b_q <= line;
                if (at_vote && state_q == ST_DATA) begin
                    shreg_q <= {vote, shreg_q[CHAR_W-1:1]};
                    bit_q   <= bit_q + BW'(1);
                end
                if (at_vote && state_q == ST_PARITY) pbit_q <= vote;
            end
        end
    end

    // outputs
    always_comb begin
        push              = !clr && tick && at_vote && (state_q == ST_STOP);
        push_char.data    = shreg_q;
        push_char.par_err = pen_q & (^shreg_q ^ pbit_q ^ podd_q);
        push_char.frm_err = ~vote;
        busy              = (state_q != ST_IDLE);
    end
endmodule

// File: rtl/osr_uart_rx_fifo.sv
module osr_uart_rx_fifo
    import osr_uart_rx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     flush,
    input  logic     push,
    input  rx_char_t wr_char,
    input  logic     pop,
    output rx_char_t head,
    output logic     not_empty,
    output logic     ovr
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int NW = $clog2(DEPTH + 1);

    rx_char_t      mem_q [DEPTH];
    logic [PW-1:0] wp_q, rp_q;
    logic [NW-1:0] n_q;
    logic          pop_ok, push_ok, drop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        pop_ok  = pop && (n_q != '0);
        push_ok = push && ((n_q != NW'(DEPTH)) || pop_ok);
        drop    = push && !push_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q <= '0;
            rp_q <= '0;
            n_q  <= '0;
            ovr  <= 1'b0;
        end else if (flush) begin
            wp_q <= '0;
            rp_q <= '0;
            n_q  <= '0;
            ovr  <= 1'b0;
        end else begin
            if (push_ok) wp_q <= bump(wp_q);
            if (pop_ok)  rp_q <= bump(rp_q);
            if (push_ok && !pop_ok)      n_q <= n_q + NW'(1);
            else if (pop_ok && !push_ok) n_q <= n_q - NW'(1);
            if (drop)        ovr <= 1'b1;
            else if (pop_ok) ovr <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!flush && push_ok) mem_q[wp_q] <= wr_char;
    end

    assign head      = mem_q[rp_q];
    assign not_empty = (n_q != '0);
endmodule

// File: rtl/osr_uart_rx.sv
module osr_uart_rx
    import osr_uart_rx_pkg::*;
#(
    parameter int OSR_NORM    = 16,
    parameter int OSR_FAST    = 8,
    parameter int QUEUE_DEPTH = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              dbl_speed,
    input  logic              rx_en,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              rxd,
    input  logic              rd_stb,
    output logic              data_avail,
    output logic [CHAR_W-1:0] rd_data,
    output logic              rd_par_err,
    output logic              rd_frm_err,
    output logic              overrun
);
    logic     line_s, push, fsm_busy, clr;
    rx_char_t new_char, head;

    assign clr = !rx_en;

    osr_uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rxd), .dout(line_s)
    );

    osr_uart_rx_fsm #(.OSR_NORM(OSR_NORM), .OSR_FAST(OSR_FAST)) u_fsm (
        .clk(clk), .rst_n(rst_n), .clr(clr), .tick(os_tick),
        .dbl_speed(dbl_speed), .par_en(par_en), .par_odd(par_odd),
        .line(line_s), .push(push), .push_char(new_char), .busy(fsm_busy)
    );

    osr_uart_rx_fifo #(.DEPTH(QUEUE_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(clr), .push(push),
        .wr_char(new_char), .pop(rd_stb), .head(head),
        .not_empty(data_avail), .ovr(overrun)
    );

    assign rd_data    = head.data;
    assign rd_par_err = head.par_err;
    assign rd_frm_err = head.frm_err;
endmodule

// File: rtl/osr_uart_rx_chk.sv
module osr_uart_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_en,
    input logic       rd_stb,
    input logic       data_avail,
    input logic [7:0] rd_data,
    input logic       rd_par_err,
    input logic       rd_frm_err,
    input logic       overrun,
    input logic       busy
);
    assert_disable_flush_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (!data_avail && !overrun && !busy));

    assert_avail_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_avail && !rd_stb && rx_en) |=> data_avail);

    assert_head_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_avail && !rd_stb && rx_en) |=>
            ($stable(rd_data) && $stable(rd_par_err) && $stable(rd_frm_err)));

    assert_read_clears_ovr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && data_avail) |=> !overrun);

    assert_ovr_needs_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> data_avail);
endmodule

bind osr_uart_rx osr_uart_rx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rd_stb(rd_stb),
    .data_avail(data_avail), .rd_data(rd_data), .rd_par_err(rd_par_err),
    .rd_frm_err(rd_frm_err), .overrun(overrun), .busy(fsm_busy)
);

// File: tb/osr_uart_rx_test.sv
`timescale 1ns/1ps
module osr_uart_rx_test;
    localparam int TDIV = 4;

    logic clk = 1'b0;
    logic rst_n, os_tick, dbl_speed, rx_en, par_en, par_odd, rxd, rd_stb;
    logic data_avail, rd_par_err, rd_frm_err, overrun;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;

    logic [7:0] m_data [2];
    bit         m_pe   [2];
    bit         m_fe   [2];
    int         m_cnt = 0;
    bit         m_ovr = 0;

    always #4 clk = ~clk;

    osr_uart_rx uut (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .dbl_speed(dbl_speed),
        .rx_en(rx_en), .par_en(par_en), .par_odd(par_odd), .rxd(rxd),
        .rd_stb(rd_stb), .data_avail(data_avail), .rd_data(rd_data),
        .rd_par_err(rd_par_err), .rd_frm_err(rd_frm_err), .overrun(overrun)
    );

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic check_state(input string tag);
        chk(data_avail == (m_cnt != 0), tag, "data_avail", int'(data_avail), int'(m_cnt != 0));
        chk(overrun == m_ovr, tag, "overrun", int'(overrun), int'(m_ovr));
        if (m_cnt != 0) begin
            chk(rd_data == m_data[0], tag, "rd_data", int'(rd_data), int'(m_data[0]));
            chk(rd_par_err == m_pe[0], tag, "rd_par_err", int'(rd_par_err), int'(m_pe[0]));
            chk(rd_frm_err == m_fe[0], tag, "rd_frm_err", int'(rd_frm_err), int'(m_fe[0]));
        end
    endtask

    function automatic void model_pop();
        if (m_cnt != 0) begin
            m_data[0] = m_data[1]; m_pe[0] = m_pe[1]; m_fe[0] = m_fe[1];
            m_cnt--;
            m_ovr = 0;
        end
    endfunction

    function automatic void model_push(input logic [7:0] d, input bit pe, input bit fe);
        if (m_cnt < 2) begin
            m_data[m_cnt] = d; m_pe[m_cnt] = pe; m_fe[m_cnt] = fe;
            m_cnt++;
        end else begin
            m_ovr = 1;
        end
    endfunction

    task automatic tick_once(input bit rd);
        repeat (TDIV - 1) @(negedge clk);
        os_tick = 1'b1;
        rd_stb  = rd;
        @(negedge clk);
        os_tick = 1'b0;
        rd_stb  = 1'b0;
    endtask

    task automatic read_one(input string tag);
        check_state(tag);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        model_pop();
        @(negedge clk);
    endtask

    // one frame; tick i samples bit i/osr; negative index disables an option
    task automatic send_frame(input logic [7:0] d, input bit fast, input bit pen, input bit podd,
                              input bit bad_par, input bit bad_stop,
                              input int corrupt_tick, input int rd_tick, input int abort_tick,
                              input string tag);
        int osr = fast ? 8 : 16;
        int nb  = pen ? 11 : 10;
        int push_tick = (nb - 1) * osr + osr / 2 + 1;
        bit bits [11];
        bit aborted = 0;
        dbl_speed = fast; par_en = pen; par_odd = podd;
        bits[0] = 1'b0;
        for (int k = 0; k < 8; k++) bits[k + 1] = d[k];
        if (pen) bits[9] = (^d) ^ podd ^ bad_par;
        bits[nb - 1] = !bad_stop;
        for (int i = 0; i < (nb + 1) * osr; i++) begin
            bit v = (i < nb * osr) ? bits[i / osr] : 1'b1;
            if (i > push_tick) v = 1'b1;
            if (i == corrupt_tick) v = !v;
            rxd = v;
            if (abort_tick >= 0 && i >= abort_tick) begin
                rx_en = 1'b0;
                if (i == abort_tick) begin
                    aborted = 1; m_cnt = 0; m_ovr = 0;
                end
            end
            if (i == rd_tick) check_state(tag);
            tick_once(i == rd_tick);
            if (i == rd_tick) model_pop();
            if (i == push_tick && !aborted) model_push(d, pen & bad_par, bad_stop);
        end
        rx_en = 1'b1;
        rxd   = 1'b1;
        @(negedge clk);
    endtask

    task automatic glitch(input bit fast, input int low_ticks);
        int osr = fast ? 8 : 16;
        dbl_speed = fast;
        for (int i = 0; i < low_ticks + 2 * osr; i++) begin
            rxd = (i < low_ticks) ? 1'b0 : 1'b1;
            tick_once(1'b0);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5EED_0042);
        rst_n = 0; os_tick = 0; dbl_speed = 0; rx_en = 1; par_en = 0; par_odd = 0;
        rxd = 1; rd_stb = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_state("R12");

        // R1 R5: 16x, no parity
        send_frame(8'hA5, 0, 0, 0, 0, 0, -1, -1, -1, "R1");
        read_one("R1 R5");
        // R2 R6: 8x, even parity, good
        send_frame(8'h3C, 1, 1, 0, 0, 0, -1, -1, -1, "R2");
        read_one("R2 R6");
        // R6: odd parity, wrong bit
        send_frame(8'h81, 0, 1, 1, 1, 0, -1, -1, -1, "R6");
        read_one("R6");
        // R7: low stop bit
        send_frame(8'h5A, 1, 0, 0, 0, 1, -1, -1, -1, "R7");
        read_one("R7");
        // R3: one centre sample of data bit 2 flipped (sample 9 at 16x)
        send_frame(8'h04, 0, 0, 0, 0, 0, 3 * 16 + 8, -1, -1, "R3");
        read_one("R3");
        send_frame(8'hF0, 1, 1, 1, 0, 0, 5 * 8 + 5, -1, -1, "R3");
        read_one("R3");
        // R4: short low pulses rejected
        glitch(0, 3);
        check_state("R4");
        glitch(1, 2);
        check_state("R4");
        // R8: read on empty queue has no effect
        read_one("R8");
        check_state("R8");
        // R8 R9: fill, overflow, order
        send_frame(8'h11, 0, 0, 0, 0, 0, -1, -1, -1, "R8");
        send_frame(8'h22, 0, 1, 0, 0, 0, -1, -1, -1, "R8");
        check_state("R8");
        send_frame(8'h33, 1, 0, 0, 0, 0, -1, -1, -1, "R9");
        check_state("R9");
        read_one("R9");
        check_state("R9");
        // R10: read on the push tick of a full queue
        send_frame(8'h44, 0, 0, 0, 0, 0, -1, -1, -1, "R10");
        check_state("R10");
        send_frame(8'h55, 0, 0, 0, 0, 0, -1, 9 * 16 + 9, -1, "R10");
        check_state("R10");
        read_one("R10");
        read_one("R10");
        check_state("R10");
        // R11: abort mid frame flushes the stored character
        send_frame(8'h66, 0, 0, 0, 0, 0, -1, -1, -1, "R11");
        send_frame(8'h77, 0, 0, 0, 0, 0, -1, -1, 60, "R11");
        check_state("R11");
        send_frame(8'h88, 1, 0, 0, 0, 0, -1, -1, 0, "R11");
        check_state("R11");
        send_frame(8'h99, 1, 1, 0, 0, 0, -1, -1, -1, "R11");
        read_one("R11");

        // random mix
        for (int n = 0; n < 40; n++) begin
            bit fast = $urandom_range(0, 1) != 0;
            bit pen  = $urandom_range(0, 1) != 0;
            int osr  = fast ? 8 : 16;
            int ct   = -1;
            if ($urandom_range(0, 1) != 0)
                ct = (1 + $urandom_range(0, 7)) * osr + osr / 2 - 1 + $urandom_range(0, 2);
            send_frame(8'($urandom), fast, pen, $urandom_range(0, 1) != 0,
                       $urandom_range(0, 3) == 0, $urandom_range(0, 7) == 0,
                       ct, -1, -1, "R3 R5 R6 R7");
            check_state("R5 R9");
            for (int r = $urandom_range(0, 2); r > 0; r--) read_one("R5 R8");
        end
        while (m_cnt != 0) read_one("R8");
        check_state("R8");
        finish_run();
    end
endmodule